// File: doc/BRIEF.md
# Three-Stage Nonlinear Feedback Pattern Generator

This block is a three-stage shift register whose entry bit comes from a nonlinear function of its own contents. Once running, its top stage emits the six-bit serial pattern 1,1,0,1,0,0 over and over, and the full three-bit state steps through six of the eight possible codes. It suits timing-pattern and test-stimulus work where a short fixed period is needed from minimal storage.

A synchronous reset places the register at the start of the pattern. A synchronous preset load lets a user seed any three-bit value, including the two codes that lie outside the cycle; each of those returns to the cycle after one enabled shift. When the enable is low and no load is requested, the register holds.

Top module: `fbseq_gen`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` becomes 3'b110 after that edge, regardless of `loadEn` and `enable`.
- R2: When `rst` is low and `loadEn` is high at an edge, `state` takes `loadValue` after that edge, whatever `enable` is.
- R3: When `rst`, `loadEn` and `enable` are all low at an edge, `state` is unchanged after that edge.
- R4: On an enabled shift (`rst` low, `loadEn` low, `enable` high), `state[2]` takes the old `state[1]` and `state[1]` takes the old `state[0]`.
- R5: On an enabled shift, `state[0]` takes the feedback bit f = (~s2 & ~s1) | (s2 & ~s0), where s2, s1, s0 are the old `state[2]`, `state[1]`, `state[0]`.
- R6: Starting from state 3'b110 with shifts enabled every cycle, `serialOut` repeats 1,1,0,1,0,0 with period 6, and `state` visits 110, 101, 010, 100, 001, 011 in that order.
- R7: An enabled shift from 3'b000 gives 3'b001 and from 3'b111 gives 3'b110; after any enabled shift `state` is neither 3'b000 nor 3'b111.
- R8: `serialOut` always equals `state[2]`, the most significant stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to 3'b110, highest priority |
| loadEn | input | 1 | Synchronous preset load request, beats shifting |
| loadValue | input | 3 | Preset value copied into the register on load |
| enable | input | 1 | Shift enable; low holds the state |
| state | output | 3 | Register contents, bit 2 is the top stage |
| serialOut | output | 1 | Serial pattern bit, the top stage |

## Verification
The two codes outside the cycle, 000 and 111, can never be reached by shifting alone, so their recovery path is only exercised when a preset load places the register there and the very next edge shifts. The stimulus does this directly with directed load-then-shift pairs for both codes, and the random phase loads arbitrary preset values between shifts so both escape codes recur many times, each followed by a compare of the next state against the bench model.

// File: rtl/fbseq_pkg.sv
package fbseq_pkg;

  localparam int STAGES = 3;
  localparam logic [STAGES-1:0] RESET_STATE = 3'b110;

  typedef struct packed {
    logic clear;
    logic load;
    logic shift;
  } seqStrobe_t;

  // Nonlinear entry bit computed from the present stages.
  function automatic logic feedbackBit(input logic [STAGES-1:0] s);
    return (~s[2] & ~s[1]) | (s[2] & ~s[0]);
  endfunction

endpackage

// File: rtl/fbseq_ctrl.sv
module fbseq_ctrl
  import fbseq_pkg::*;
(
  input  logic       rst,
  input  logic       loadEn,
  input  logic       enable,
  output seqStrobe_t strobe
);

  // Priority: clear over load over shift.
  always_comb begin
    strobe       = '0;
    strobe.clear = rst;
    strobe.load  = !rst && loadEn;
    strobe.shift = !rst && !loadEn && enable;
  end

endmodule

// File: rtl/fbseq_datapath.sv
module fbseq_datapath
  import fbseq_pkg::*;
(
  input  logic              clk,
  input  seqStrobe_t        strobe,
  input  logic [STAGES-1:0] loadValue,
  output logic [STAGES-1:0] stageQ
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] shifted;
  logic              entryBit;

  assign entryBit = feedbackBit(stageQ);

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      assign shifted[i] = stageQ[i-1];
    end
  endgenerate
  assign shifted[0] = entryBit;

  always_ff @(posedge clk) begin
    if (strobe.clear)      stageQ <= RESET_STATE;
    else if (strobe.load)  stageQ <= loadValue;
    else if (strobe.shift) stageQ <= shifted;
  end

endmodule

// File: rtl/fbseq_gen.sv
module fbseq_gen
  import fbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loadEn,
  input  logic [2:0] loadValue,
  input  logic       enable,
  output logic [2:0] state,
  output logic       serialOut
);

  seqStrobe_t strobe;

  fbseq_ctrl ctrl_i (
    .rst    (rst),
    .loadEn (loadEn),
    .enable (enable),
    .strobe (strobe)
  );

  fbseq_datapath dp_i (
    .clk       (clk),
    .strobe    (strobe),
    .loadValue (loadValue),
    .stageQ    (state)
  );

  assign serialOut = state[STAGES-1];

endmodule

// File: rtl/fbseq_gen_checker.sv
module fbseq_gen_checker (
  input logic       clk,
  input logic       rst,
  input logic       loadEn,
  input logic [2:0] loadValue,
  input logic       enable,
  input logic [2:0] state,
  input logic       serialOut
);

  assert_reset_R1: assert property (@(posedge clk) rst |=> state == 3'b110);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> state == $past(loadValue));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !enable) |=> $stable(state));

  assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && enable) |=> state[2:1] == $past(state[1:0]));

  assert_zero_escape_R7: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && enable && state == 3'b000) |=> state == 3'b001);

  assert_ones_escape_R7: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && enable && state == 3'b111) |=> state == 3'b110);

  assert_in_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && enable) |=> (state != 3'b000 && state != 3'b111));

  assert_top_stage_R8: assert property (@(posedge clk) serialOut == state[2]);

endmodule

bind fbseq_gen fbseq_gen_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .loadEn    (loadEn),
  .loadValue (loadValue),
  .enable    (enable),
  .state     (state),
  .serialOut (serialOut)
);

// File: tb/fbseq_gen_tb.sv
module fbseq_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadEn = 1'b0;
  logic [2:0] loadValue = 3'b000;
  logic       enable = 1'b0;
  logic [2:0] state;
  logic       serialOut;

  int vectors = 0;
  int misses  = 0;
  logic [2:0] model = 3'b110;

  always #5 clk = ~clk;

  fbseq_gen dut_i (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadValue(loadValue),
    .enable(enable), .state(state), .serialOut(serialOut)
  );

  function automatic logic [2:0] predict(input logic [2:0] s, input logic r,
                                         input logic l, input logic [2:0] v,
                                         input logic e);
    logic f;
    f = (!s[2] && !s[1]) || (s[2] && !s[0]);
    if (r) return 3'b110;
    if (l) return v;
    if (e) return {s[1], s[0], f};
    return s;
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input string tag, input logic r, input logic l,
                      input logic [2:0] v, input logic e);
    rst = r; loadEn = l; loadValue = v; enable = e;
    model = predict(model, r, l, v, e);
    @(posedge clk);
    @(negedge clk);
    check(tag, state, model);
    check("R8", {2'b00, serialOut}, {2'b00, state[2]});
  endtask

  initial begin
    #2_000_000;
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [5:0] pattern;
    int seed;
    seed = 17;
    void'($urandom(seed));
    @(negedge clk);
    // R1: reset state, even with load and enable asserted
    step("R1", 1'b1, 1'b1, 3'b011, 1'b1);
    check("R1", state, 3'b110);
    // R6: serial pattern over two periods
    pattern = 6'b110100;
    for (int k = 0; k < 12; k++) begin
      check("R6", {2'b00, serialOut}, {2'b00, pattern[5 - (k % 6)]});
      step("R6", 1'b0, 1'b0, 3'b000, 1'b1);
    end
    check("R6", state, 3'b110);
    // R7: escape from 000 and 111
    step("R2", 1'b0, 1'b1, 3'b000, 1'b0);
    step("R7", 1'b0, 1'b0, 3'b000, 1'b1);
    check("R7", state, 3'b001);
    step("R2", 1'b0, 1'b1, 3'b111, 1'b1);
    step("R7", 1'b0, 1'b0, 3'b000, 1'b1);
    check("R7", state, 3'b110);
    // R3: hold with enable low, loadValue wiggling
    step("R3", 1'b0, 1'b0, 3'b001, 1'b0);
    step("R3", 1'b0, 1'b0, 3'b010, 1'b0);
    check("R3", state, 3'b110);
    // R4 R5: random mix of reset, load, shift and hold
    for (int n = 0; n < 3000; n++) begin
      logic r, l, e;
      logic [2:0] v;
      r = ($urandom % 32) == 0;
      l = ($urandom % 4) == 0;
      e = ($urandom % 4) != 0;
      v = 3'($urandom);
      step("R4/R5", r, l, v, e);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule